// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block is the host side of a 16-bit parallel NOR flash. A client hands it one request at a time: identify the device, read one array word, erase a block, or program a page. The sequencer turns the request into an ordered series of command and data bus cycles. Each bus cycle has a set-up, strobe and hold phase, each a parameter number of clock cycles long. For erase and program it then polls the device status word at a fixed interval until the ready bit appears or a cycle budget runs out.

Every operation leaves the device in array-read mode. A clean finish writes only the read-array command. A failed status, a failed identification or a timeout first writes clear-status and then read-array. The outcome is reported with a one-cycle `done` pulse, a two-bit result (0 pass, 1 fail, 2 timeout), the last status byte and the last word read. Program data arrives on a valid/ready word stream, one page of words per request.

The controller states are IDLE, PRE_FF, ID_CMD, RD_WORD, ER_CMD, ER_CONF, PG_CMD, PG_DATA, POLL_WAIT, POLL_RD, EXIT_CLR, EXIT_FF and DONE. The transitions are:
- IDLE goes to PRE_FF for identify or read, to ER_CMD for erase, and to PG_CMD for program.
- PRE_FF goes to ID_CMD for identify, otherwise to RD_WORD. ID_CMD goes to RD_WORD.
- RD_WORD goes to EXIT_CLR on an identify mismatch, otherwise to EXIT_FF.
- ER_CMD goes to ER_CONF, and ER_CONF goes to POLL_WAIT.
- PG_CMD goes to PG_DATA. PG_DATA goes to POLL_WAIT after the last word.
- POLL_WAIT goes to POLL_RD when the interval ends, or to EXIT_CLR on timeout.
- POLL_RD goes to EXIT_FF when the device is ready with no error. It goes to EXIT_CLR on ready with an error or on timeout. Otherwise it goes back to POLL_WAIT.
- EXIT_CLR goes to EXIT_FF, EXIT_FF goes to DONE, and DONE goes to IDLE.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset the block is idle: `busy`=0, `req_ready`=1, `fl_ce_n`=`fl_we_n`=`fl_oe_n`=1, `fl_dq_oe`=0, `result`=0.
- R2: In every bus cycle, chip enable is low for TSU+TPW+THD clocks. The write or output strobe is low for exactly TPW clocks. The address and write data stay stable for the whole cycle, and `fl_dq_oe` is high throughout a write.
- R3: The flash word address used for commands is `req_addr` with bit 0 dropped, so odd byte addresses are forced to even alignment.
- R4: A request is taken only in IDLE. `req_op` is 0 identify, 1 read, 2 erase, 3 program. Erase writes 0x20 and then 0xD0 to the block word address.
- R5: Status is read with POLL_GAP idle clocks between reads. The read with bit 7 set ends polling, so N busy reads lead to exactly N+1 reads. If bit 7 is not seen within TIMEOUT polling clocks, the result is 2.
- R6: On a ready status, any of bits 5, 4 or 3 set gives result 1. Bit 6 alone gives result 0. `status_byte` holds the last status read.
- R7: A pass ends with one write of 0xFF. A fail or timeout ends with 0x50 and then 0xFF. Both go to the operation's word address.
- R8: Program writes 0x41 to the page base, which is the word address with its low log2(PAGE_WORDS) bits cleared. It then writes PAGE_WORDS stream words to base+0 and onward, taking one word per `wd_valid`/`wd_ready` handshake. Each stream word is expected to carry the lower-addressed byte in bits 15:8.
- R9: `busy` stays high from acceptance through the final 0xFF write. `req_valid` while busy has no effect: no extra bus cycle occurs.
- R10: Identify writes 0xFF and then 0x90, then reads a word. `id_match` is 1 and the result is 0 exactly when the low byte is 0x1C. Otherwise the result is 1.
- R11: Read writes 0xFF, reads one word into `rd_word`, then writes 0xFF. The result is 0.
- R12: The write and output strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| req_valid | input | 1 | request strobe |
| req_ready | output | 1 | high when a request can be taken |
| req_op | input | 2 | 0 identify, 1 read, 2 erase, 3 program |
| req_addr | input | ADDR_W+1 | byte address |
| wd_valid | input | 1 | program word valid |
| wd_ready | output | 1 | program word taken |
| wd_data | input | 16 | program word |
| busy | output | 1 | operation in progress |
| done | output | 1 | one-cycle completion pulse |
| result | output | 2 | 0 pass, 1 fail, 2 timeout |
| status_byte | output | 8 | last status read |
| rd_word | output | 16 | last word read in identify or read |
| id_match | output | 1 | maker code matched |
| fl_addr | output | ADDR_W | flash word address |
| fl_dq_out | output | 16 | flash write data |
| fl_dq_oe | output | 1 | data bus drive enable |
| fl_dq_in | input | 16 | flash read data |
| fl_ce_n | output | 1 | chip enable, low active |
| fl_we_n | output | 1 | write enable, low active |
| fl_oe_n | output | 1 | output enable, low active |

## Verification
The assertions assume the flash returns a stable word on `fl_dq_in` while the output strobe is low. They also assume `req_op` and `req_addr` are only meaningful while `req_valid` is high in IDLE. The bench's flash model changes its read value only on strobe rising edges, so the first assumption holds. Stray requests are raised only while `busy` is high, where they are required to be ignored. Program stream words are presented with a stall pattern, so the handshake is exercised with gaps.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;
    localparam logic [7:0] CMD_ARRAY   = 8'hFF;
    localparam logic [7:0] CMD_IDENT   = 8'h90;
    localparam logic [7:0] CMD_CLEAR   = 8'h50;
    localparam logic [7:0] CMD_ERASE   = 8'h20;
    localparam logic [7:0] CMD_CONFIRM = 8'hD0;
    localparam logic [7:0] CMD_PAGE    = 8'h41;
    localparam logic [7:0] MAKER_CODE  = 8'h1C;

    typedef enum logic [1:0] {OP_IDENT = 2'd0, OP_READ = 2'd1, OP_ERASE = 2'd2, OP_PROG = 2'd3} op_t;
    typedef enum logic [1:0] {RES_PASS = 2'd0, RES_FAIL = 2'd1, RES_TMO = 2'd2} res_t;
    typedef enum logic [1:0] {B_IDLE, B_SETUP, B_PULSE, B_HOLD} bus_st_t;
    typedef enum logic [3:0] {
        S_IDLE, S_PRE_FF, S_ID_CMD, S_RD_WORD, S_ER_CMD, S_ER_CONF, S_PG_CMD,
        S_PG_DATA, S_POLL_WAIT, S_POLL_RD, S_EXIT_CLR, S_EXIT_FF, S_DONE
    } seq_st_t;
endpackage

// File: rtl/nor_bus_cycle.sv
module nor_bus_cycle
    import nor_seq_pkg::*;
#(
    parameter int AW  = 22,
    parameter int TSU = 2,
    parameter int TPW = 3,
    parameter int THD = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [15:0]   wdata,
    output logic          fin,
    output logic [15:0]   rdata,
    output logic [AW-1:0] fl_addr,
    output logic [15:0]   fl_dq_out,
    output logic          fl_dq_oe,
    input  logic [15:0]   fl_dq_in,
    output logic          fl_ce_n,
    output logic          fl_we_n,
    output logic          fl_oe_n
);
    localparam int CMAX = (TSU > TPW) ? ((TSU > THD) ? TSU : THD) : ((TPW > THD) ? TPW : THD);
    localparam int CW   = $clog2(CMAX + 1);

    bus_st_t       st;
    logic [CW-1:0] cnt;
    logic          wr_q;
    logic [AW-1:0] addr_q;
    logic [15:0]   data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= B_IDLE;
            cnt    <= '0;
            wr_q   <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
            rdata  <= '0;
        end else begin
            unique case (st)
                B_IDLE: if (start) begin
                    st     <= B_SETUP;
                    cnt    <= '0;
                    wr_q   <= wr;
                    addr_q <= addr;
                    data_q <= wdata;
                end
                B_SETUP: if (cnt == CW'(TSU - 1)) begin
                    st  <= B_PULSE;
                    cnt <= '0;
                end else cnt <= cnt + 1'b1;
                B_PULSE: if (cnt == CW'(TPW - 1)) begin
                    if (!wr_q) rdata <= fl_dq_in;
                    st  <= B_HOLD;
                    cnt <= '0;
                end else cnt <= cnt + 1'b1;
                B_HOLD: if (cnt == CW'(THD - 1)) begin
                    st  <= B_IDLE;
                    cnt <= '0;
                end else cnt <= cnt + 1'b1;
                default: st <= B_IDLE;
            endcase
        end
    end

    always_comb begin
        fl_ce_n   = (st == B_IDLE);
        fl_we_n   = !((st == B_PULSE) && wr_q);
        fl_oe_n   = !((st == B_PULSE) && !wr_q);
        fl_dq_oe  = wr_q && (st != B_IDLE);
        fl_addr   = addr_q;
        fl_dq_out = data_q;
        fin       = (st == B_HOLD) && (cnt == CW'(THD - 1));
    end

    // R12: strobes never overlap
    a_r12_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fl_we_n && !fl_oe_n));
    // R2: a write strobe sits inside chip enable with the data bus driven
    a_r2_we_inside_ce: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> (!fl_ce_n && fl_dq_oe));
    // R2: address held for the whole cycle
    a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_ce_n && $past(!fl_ce_n) && $past(st) != B_HOLD) |-> $stable(fl_addr));
endmodule

// File: rtl/nor_poll_timer.sv
module nor_poll_timer #(
    parameter int TIMEOUT  = 1000000,
    parameter int POLL_GAP = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic gap_run,
    output logic tmo,
    output logic gap_hit
);
    localparam int TW = $clog2(TIMEOUT + 1);
    localparam int GW = $clog2(POLL_GAP + 1);

    logic [TW-1:0] tot;
    logic [GW-1:0] gap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tot <= '0;
            gap <= '0;
        end else begin
            if (!run) tot <= '0;
            else if (tot != TW'(TIMEOUT)) tot <= tot + 1'b1;
            if (!gap_run || gap_hit) gap <= '0;
            else gap <= gap + 1'b1;
        end
    end

    assign tmo     = (tot == TW'(TIMEOUT));
    assign gap_hit = gap_run && (gap == GW'(POLL_GAP - 1));

    // R5: the polling budget counter never passes its limit
    a_r5_total_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        tot <= TW'(TIMEOUT));
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int ADDR_W     = 22,
    parameter int PAGE_WORDS = 128,
    parameter int TSU        = 2,
    parameter int TPW        = 3,
    parameter int THD        = 1,
    parameter int TIMEOUT    = 1000000,
    parameter int POLL_GAP   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W:0]   req_addr,
    input  logic              wd_valid,
    output logic              wd_ready,
    input  logic [15:0]       wd_data,
    output logic              busy,
    output logic              done,
    output logic [1:0]        result,
    output logic [7:0]        status_byte,
    output logic [15:0]       rd_word,
    output logic              id_match,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [15:0]       fl_dq_out,
    output logic              fl_dq_oe,
    input  logic [15:0]       fl_dq_in,
    output logic              fl_ce_n,
    output logic              fl_we_n,
    output logic              fl_oe_n
);
    localparam int PB = $clog2(PAGE_WORDS);

    seq_st_t           st, st_nx;
    op_t               op_q;
    logic [ADDR_W-1:0] op_addr;
    logic [PB-1:0]     idx;
    logic              pend;
    logic              b_start, b_wr, b_fin;
    logic [ADDR_W-1:0] b_addr;
    logic [15:0]       b_data, b_rdata;
    logic              tmo, gap_hit, st_err, id_ok;
    logic [ADDR_W-1:0] word_addr;

    assign word_addr = req_addr[ADDR_W:1];
    assign st_err    = b_rdata[5] | b_rdata[4] | b_rdata[3];
    assign id_ok     = (b_rdata[7:0] == MAKER_CODE);

    nor_bus_cycle #(.AW(ADDR_W), .TSU(TSU), .TPW(TPW), .THD(THD)) u_bus (
        .clk(clk), .rst_n(rst_n), .start(b_start), .wr(b_wr), .addr(b_addr),
        .wdata(b_data), .fin(b_fin), .rdata(b_rdata), .fl_addr(fl_addr),
        .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in),
        .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n));

    nor_poll_timer #(.TIMEOUT(TIMEOUT), .POLL_GAP(POLL_GAP)) u_tmr (
        .clk(clk), .rst_n(rst_n),
        .run((st == S_POLL_WAIT) || (st == S_POLL_RD)),
        .gap_run(st == S_POLL_WAIT), .tmo(tmo), .gap_hit(gap_hit));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE: if (req_valid) begin
                unique case (op_t'(req_op))
                    OP_ERASE: st_nx = S_ER_CMD;
                    OP_PROG:  st_nx = S_PG_CMD;
                    default:  st_nx = S_PRE_FF;
                endcase
            end
            S_PRE_FF:    if (b_fin) st_nx = (op_q == OP_IDENT) ? S_ID_CMD : S_RD_WORD;
            S_ID_CMD:    if (b_fin) st_nx = S_RD_WORD;
            S_RD_WORD:   if (b_fin) st_nx = (op_q == OP_IDENT && !id_ok) ? S_EXIT_CLR : S_EXIT_FF;
            S_ER_CMD:    if (b_fin) st_nx = S_ER_CONF;
            S_ER_CONF:   if (b_fin) st_nx = S_POLL_WAIT;
            S_PG_CMD:    if (b_fin) st_nx = S_PG_DATA;
            S_PG_DATA:   if (b_fin && idx == PB'(PAGE_WORDS - 1)) st_nx = S_POLL_WAIT;
            S_POLL_WAIT: if (tmo) st_nx = S_EXIT_CLR;
                         else if (gap_hit) st_nx = S_POLL_RD;
            S_POLL_RD:   if (b_fin) begin
                if (b_rdata[7]) st_nx = st_err ? S_EXIT_CLR : S_EXIT_FF;
                else            st_nx = tmo ? S_EXIT_CLR : S_POLL_WAIT;
            end
            S_EXIT_CLR:  if (b_fin) st_nx = S_EXIT_FF;
            S_EXIT_FF:   if (b_fin) st_nx = S_DONE;
            S_DONE:      st_nx = S_IDLE;
            default:     st_nx = S_IDLE;
        endcase
    end

    // outputs toward bus engine and ports
    always_comb begin
        b_start  = 1'b0;
        b_wr     = 1'b1;
        b_addr   = op_addr;
        b_data   = '0;
        wd_ready = 1'b0;
        unique case (st)
            S_PRE_FF, S_EXIT_FF: begin b_data = {8'h00, CMD_ARRAY};   b_start = !pend; end
            S_ID_CMD:            begin b_data = {8'h00, CMD_IDENT};   b_start = !pend; end
            S_ER_CMD:            begin b_data = {8'h00, CMD_ERASE};   b_start = !pend; end
            S_ER_CONF:           begin b_data = {8'h00, CMD_CONFIRM}; b_start = !pend; end
            S_PG_CMD:            begin b_data = {8'h00, CMD_PAGE};    b_start = !pend; end
            S_EXIT_CLR:          begin b_data = {8'h00, CMD_CLEAR};   b_start = !pend; end
            S_RD_WORD, S_POLL_RD: begin b_wr = 1'b0; b_start = !pend; end
            S_PG_DATA: begin
                wd_ready = !pend;
                b_start  = !pend && wd_valid;
                b_addr   = op_addr + ADDR_W'(idx);
                b_data   = wd_data;
            end
            default: ;
        endcase
        busy      = (st != S_IDLE);
        req_ready = (st == S_IDLE);
        done      = (st == S_DONE);
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q        <= OP_IDENT;
            op_addr     <= '0;
            idx         <= '0;
            pend        <= 1'b0;
            result      <= RES_PASS;
            status_byte <= '0;
            rd_word     <= '0;
            id_match    <= 1'b0;
        end else begin
            if (b_start)    pend <= 1'b1;
            else if (b_fin) pend <= 1'b0;
            if (st == S_IDLE && req_valid) begin
                op_q     <= op_t'(req_op);
                op_addr  <= (op_t'(req_op) == OP_PROG) ? {word_addr[ADDR_W-1:PB], PB'(0)} : word_addr;
                idx      <= '0;
                result   <= RES_PASS;
                id_match <= 1'b0;
            end
            if (st == S_RD_WORD && b_fin) begin
                rd_word <= b_rdata;
                if (op_q == OP_IDENT) begin
                    id_match <= id_ok;
                    if (!id_ok) result <= RES_FAIL;
                end
            end
            if (st == S_PG_DATA && b_fin) idx <= idx + 1'b1;
            if (st == S_POLL_WAIT && tmo) result <= RES_TMO;
            if (st == S_POLL_RD && b_fin) begin
                status_byte <= b_rdata[7:0];
                if (b_rdata[7] && st_err) result <= RES_FAIL;
                else if (!b_rdata[7] && tmo) result <= RES_TMO;
            end
        end
    end

    // R9: the captured operation cannot change while busy
    a_r9_op_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(op_q) && $stable(op_addr)));
    // R9: busy drops only right after the completion pulse
    a_r9_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));
    // R6: a reported erase/program failure is backed by a ready status with an error bit
    a_r6_fail_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == RES_FAIL && (op_q == OP_ERASE || op_q == OP_PROG))
            |-> (status_byte[7] && (status_byte[5] || status_byte[4] || status_byte[3])));
    // R5: no result code outside pass/fail/timeout
    a_r5_result_code: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result != 2'd3));
endmodule

// File: tb/tb_nor_cmd_seq.sv
module tb_nor_cmd_seq;
    localparam int AW = 22, PW = 4, TSU = 1, TPW = 2, THD = 1, TMO = 300, GAP = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, wd_valid, wd_ready;
    logic [1:0] req_op = '0;
    logic [AW:0] req_addr = '0;
    logic [15:0] wd_data, rd_word, fl_dq_out, fl_dq_in;
    logic req_ready, busy, done, id_match, fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n;
    logic [1:0] result;
    logic [7:0] status_byte;
    logic [AW-1:0] fl_addr;

    always #5 clk = ~clk;

    nor_cmd_seq #(.ADDR_W(AW), .PAGE_WORDS(PW), .TSU(TSU), .TPW(TPW), .THD(THD),
                  .TIMEOUT(TMO), .POLL_GAP(GAP)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .wd_valid(wd_valid), .wd_ready(wd_ready),
        .wd_data(wd_data), .busy(busy), .done(done), .result(result),
        .status_byte(status_byte), .rd_word(rd_word), .id_match(id_match),
        .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in),
        .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n));

    int n_chk = 0, n_bad = 0, cyc = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- flash model ----------------
    typedef enum int {M_ARR, M_ID, M_STAT} mode_t;
    mode_t mode = M_ARR;
    int busy_left = 0, busy_set = 0, pg_left = 0, n_rd = 0, nw = 0, we_w = 0, oe_w = 0;
    logic [7:0] err_bits = 8'h00;
    logic [15:0] id_word = 16'h201C;
    logic we_q = 1'b1, oe_q = 1'b1;
    logic [AW-1:0] wa [0:63];
    logic [15:0]   wd [0:63];
    int            wc [0:63];

    function automatic logic [15:0] arr(input logic [AW-1:0] a);
        return a[15:0] ^ 16'hA5C3;
    endfunction

    assign fl_dq_in = (mode == M_ARR) ? arr(fl_addr) :
                      (mode == M_ID)  ? id_word :
                      (busy_left > 0) ? 16'h0000 : {8'h00, 8'h80 | err_bits};

    always @(posedge clk) begin
        cyc++;
        we_q <= fl_we_n;
        oe_q <= fl_oe_n;
        if (!fl_we_n) we_w++;
        if (!fl_oe_n) oe_w++;
        if (!we_q && fl_we_n) begin
            chk(we_w == TPW, "R2 write strobe width", we_w, TPW);
            we_w = 0;
            if (nw < 64) begin wa[nw] = fl_addr; wd[nw] = fl_dq_out; wc[nw] = cyc; end
            nw++;
            if (pg_left > 0) pg_left--;
            else case (fl_dq_out[7:0])
                8'hFF: mode = M_ARR;
                8'h90: mode = M_ID;
                8'h20, 8'h70: mode = M_STAT;
                8'hD0: begin mode = M_STAT; busy_left = busy_set; end
                8'h41: begin mode = M_STAT; busy_left = busy_set; pg_left = PW; end
                default: ;
            endcase
        end
        if (!oe_q && fl_oe_n) begin
            chk(oe_w == TPW, "R2 read strobe width", oe_w, TPW);
            oe_w = 0;
            if (mode == M_STAT) begin
                n_rd++;
                if (busy_left > 0) busy_left--;
            end
        end
    end

    // ---------------- program stream ----------------
    logic [15:0] pwd [0:PW-1];
    int sidx = 0;
    logic stream_en = 1'b0, stall = 1'b0;
    assign wd_valid = stream_en && (sidx < PW) && !stall;
    assign wd_data  = (sidx < PW) ? pwd[sidx] : 16'h0;
    always @(posedge clk) begin
        if (wd_valid && wd_ready) sidx <= sidx + 1;
        stall <= ~stall;
    end

    // ---------------- helpers ----------------
    task automatic run_op(input logic [1:0] op, input logic [AW:0] a, input bit poke);
        nw = 0; n_rd = 0;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 4000 && !done; i++) begin
            if (poke && i >= 3 && i < 6) begin req_valid = 1'b1; req_op = 2'd1; end
            else req_valid = 1'b0;
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(done == 1'b1, "R9 operation completes", done, 1);
    endtask

    task automatic chk_w(input int k, input logic [AW-1:0] a, input logic [15:0] d, input string req);
        chk(wa[k] == a, req, wa[k], a);
        chk(wd[k][7:0] == d[7:0] && (d[15:8] == 8'h00 || wd[k] == d), req, wd[k], d);
    endtask

    task automatic chk_tail(input int base, input logic [AW-1:0] a, input bit clean);
        if (clean) begin
            chk(nw == base + 1, "R7 pass exit write count", nw, base + 1);
            chk_w(base, a, 16'h00FF, "R7 pass exit read-array");
        end else begin
            chk(nw == base + 2, "R7 fail exit write count", nw, base + 2);
            chk_w(base, a, 16'h0050, "R7 exit clear-status");
            chk_w(base + 1, a, 16'h00FF, "R7 exit read-array");
        end
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy == 0 && req_ready == 1, "R1 idle after reset", {busy, req_ready}, 2'b01);
        chk(fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe, "R1 strobes inactive",
            {fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe}, 4'b1110);
        chk(result == 0, "R1 result cleared", result, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R11 / R3 read sweep, including odd byte addresses
        for (int k = 0; k < 5; k++) begin
            logic [AW:0] ba = 23'(k * 12345 + k);
            logic [AW-1:0] w = ba[AW:1];
            run_op(2'd1, ba, 0);
            chk(rd_word == arr(w), "R11 read word", rd_word, arr(w));
            chk(result == 0, "R11 read result", result, 0);
            chk(nw == 2, "R11 write count", nw, 2);
            chk_w(0, w, 16'h00FF, "R3 R11 pre read-array");
            chk_w(1, w, 16'h00FF, "R11 exit read-array");
        end

        // R10 identify, match and mismatch
        for (int k = 0; k < 2; k++) begin
            id_word = k == 0 ? 16'h201C : 16'h1C55;
            run_op(2'd0, 23'h0000, 0);
            chk(id_match == (k == 0), "R10 id_match", id_match, k == 0);
            chk(result == (k == 0 ? 0 : 1), "R10 result", result, k == 0 ? 0 : 1);
            chk(rd_word == id_word, "R10 id word", rd_word, id_word);
            chk_w(0, 22'h0, 16'h00FF, "R10 first read-array");
            chk_w(1, 22'h0, 16'h0090, "R10 identify command");
            chk_tail(2, 22'h0, k == 0);
        end

        // R4 R5 erase with a sweep of busy lengths, stray requests while busy (R9)
        for (int bp = 0; bp < 6; bp++) begin
            logic [AW:0] ba = 23'(bp * 65536 + 2 * bp + 1);
            logic [AW-1:0] w = ba[AW:1];
            busy_set = bp; err_bits = 8'h00;
            run_op(2'd2, ba, bp == 2);
            chk(result == 0, "R5 erase pass", result, 0);
            chk(n_rd == bp + 1, "R5 status reads", n_rd, bp + 1);
            chk(status_byte == 8'h80, "R6 status byte", status_byte, 8'h80);
            chk_w(0, w, 16'h0020, "R4 erase command");
            chk_w(1, w, 16'h00D0, "R4 erase confirm");
            chk_tail(2, w, 1);
            if (bp == 2) begin
                repeat (10) @(negedge clk);
                chk(nw == 3 && !busy, "R9 stray request ignored", nw, 3);
            end
        end

        // R6 each status bit after ready
        for (int b = 3; b < 7; b++) begin
            busy_set = 1; err_bits = 8'(1 << b);
            run_op(2'd2, 23'h1000, 0);
            chk(result == (b == 6 ? 0 : 1), "R6 error decode", result, b == 6 ? 0 : 1);
            chk(status_byte == (8'h80 | err_bits), "R6 status byte", status_byte, 8'h80 | err_bits);
            chk_tail(2, 22'h800, b == 6);
        end

        // R5 timeout
        busy_set = 100000; err_bits = 8'h00;
        run_op(2'd2, 23'h2000, 0);
        chk(result == 2, "R5 timeout result", result, 2);
        chk(n_rd >= 1 && n_rd <= TMO / GAP + 1, "R5 timeout poll count", n_rd, TMO / GAP);
        chk(wc[2] - wc[1] >= TMO, "R5 timeout elapsed", wc[2] - wc[1], TMO);
        chk_tail(2, 22'h1000, 0);
        busy_left = 0;

        // R8 page program, two pages with unaligned addresses
        for (int p = 0; p < 2; p++) begin
            logic [AW:0] ba = 23'(p * 1000 + 7);
            logic [AW-1:0] base = {ba[AW:3], 2'b00};
            for (int i = 0; i < PW; i++) begin
                logic [7:0] lo = 8'(2 * i * 7 + p * 31);
                logic [7:0] hi = 8'((2 * i + 1) * 7 + p * 31);
                pwd[i] = {lo, hi};
            end
            sidx = 0; stream_en = 1'b1; busy_set = p + 1; err_bits = 8'h00;
            run_op(2'd3, ba, 0);
            stream_en = 1'b0;
            chk(result == 0, "R8 program result", result, 0);
            chk(nw == PW + 2, "R8 program write count", nw, PW + 2);
            chk_w(0, base, 16'h0041, "R8 page command");
            for (int i = 0; i < PW; i++) begin
                chk(wa[i + 1] == base + AW'(i), "R8 data address", wa[i + 1], base + AW'(i));
                chk(wd[i + 1] == pwd[i], "R8 data word", wd[i + 1], pwd[i]);
            end
            chk_tail(PW + 1, base, 1);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule